// File: doc/BRIEF.md
# Per-Thread Squash Request Arbiter

This block sits between the execute stage of an out-of-order core and its commit stage. In any cycle, execute can raise two kinds of flush request for each hardware thread. One is a branch misprediction, which carries the branch's sequence number and its corrected target. The other is a memory-order violation, which carries the sequence number and PC of the younger load that read stale data. The violation request also carries the sequence number of the older store that found the conflict. For every thread, the arbiter picks a single squash command and registers it for commit on the next clock edge.

Requests are folded in a fixed order: the branch first, then the violation. A request takes the thread's slot if the slot is empty, or if its sequence number is older than or equal to the one already held. A smaller unsigned number is older. Because of the equal case, a violation on the same instruction as a mispredicted branch wins the tie. A winning violation flushes the load itself and refetches at the load's own PC.

A branch winner flushes only the instructions younger than the branch and redirects to the corrected target. Each thread also keeps a free-running count of violation events. The command outputs hold for one cycle only. They drop back to idle in any cycle that follows one with no request.

Top module: `sq_arb`

## Requirements
- R1: While rst_ni is low, every squash output and every violation counter reads zero.
- R2: When a thread had no request in the previous cycle, its sq_valid_o is 0 after the next clock edge.
- R3: A branch request alone gives, one cycle later: sq_valid_o=1, sq_seq_o = the branch sequence number, sq_pc_o = the corrected target, sq_incl_o=0 and sq_mispred_o=1.
- R4: A violation request alone gives, one cycle later: sq_valid_o=1, sq_seq_o = the load's sequence number, sq_pc_o = the load's own PC unmodified, sq_incl_o=1 and sq_mispred_o=0.
- R5: When both requests arrive and the load's sequence number is smaller than the branch's, the violation command of R4 is issued.
- R6: When both requests arrive with equal sequence numbers, the violation command of R4 is issued.
- R7: When both requests arrive and the branch's sequence number is smaller, the branch command of R3 is issued.
- R8: The detecting store's sequence number (vl_det_seq_i) has no effect on any squash output. It must differ from the load's sequence number.
- R9: viol_cnt_o of a thread increases by exactly one, modulo 2^CNT_W, in each cycle that thread has a violation request, whether or not the violation wins. Otherwise it holds.
- R10: Each thread's outputs depend only on that thread's own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | NUM_THR | Branch mispredict request per thread |
| br_seq_i | input | NUM_THR x SEQ_W | Branch sequence number |
| br_tgt_i | input | NUM_THR x PC_W | Corrected branch target |
| vl_valid_i | input | NUM_THR | Memory-order violation request per thread |
| vl_seq_i | input | NUM_THR x SEQ_W | Violating load sequence number |
| vl_pc_i | input | NUM_THR x PC_W | Violating load PC |
| vl_det_seq_i | input | NUM_THR x SEQ_W | Sequence number of the store that detected the violation |
| sq_valid_o | output | NUM_THR | Squash command valid |
| sq_seq_o | output | NUM_THR x SEQ_W | Squash boundary sequence number |
| sq_pc_o | output | NUM_THR x PC_W | Redirect PC |
| sq_incl_o | output | NUM_THR | Squash includes the boundary instruction |
| sq_mispred_o | output | NUM_THR | Command comes from a branch mispredict |
| viol_cnt_o | output | NUM_THR x CNT_W | Violation event counter |

## Verification
A branch mispredict and a memory-order violation can reach the same thread in the same cycle. In that case the arbiter must rank them by age, and on an exact tie the violation must win. The bench covers this with a full sweep of both valid bits and both sequence numbers on one thread, while a second thread runs an unrelated pattern. Each registered command is checked against an ordering model computed in the bench. The checks cover the winner's sequence number, the PC, the include flag, the mispredict flag and the event counter, which must count every violation, including those that lose.

// File: rtl/sq_arb_pkg.sv
package sq_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BR   = 2'd1,
    SRC_VIOL = 2'd2
  } sq_src_e;
endpackage

// File: rtl/sq_arb_pick.sv
module sq_arb_pick
  import sq_arb_pkg::*;
#(
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned PC_W  = 32
) (
  input  logic             br_valid_i,
  input  logic [SEQ_W-1:0] br_seq_i,
  input  logic [PC_W-1:0]  br_tgt_i,
  input  logic             vl_valid_i,
  input  logic [SEQ_W-1:0] vl_seq_i,
  input  logic [PC_W-1:0]  vl_pc_i,
  output sq_src_e          src_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [PC_W-1:0]  pc_o
);
  // fold order: branch, then violation; <= lets violation take a tie
  always_comb begin
    src_o = SRC_NONE;
    seq_o = '0;
    pc_o  = '0;
    if (br_valid_i) begin
      src_o = SRC_BR;
      seq_o = br_seq_i;
      pc_o  = br_tgt_i;
    end
    if (vl_valid_i && (src_o == SRC_NONE || vl_seq_i <= seq_o)) begin
      src_o = SRC_VIOL;
      seq_o = vl_seq_i;
      pc_o  = vl_pc_i;
    end
  end
endmodule

// File: rtl/sq_arb_evt_cnt.sv
module sq_arb_evt_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sq_arb.sv
module sq_arb
  import sq_arb_pkg::*;
#(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned SEQ_W   = 8,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_THR-1:0]             br_valid_i,
  input  logic [NUM_THR-1:0][SEQ_W-1:0]  br_seq_i,
  input  logic [NUM_THR-1:0][PC_W-1:0]   br_tgt_i,
  input  logic [NUM_THR-1:0]             vl_valid_i,
  input  logic [NUM_THR-1:0][SEQ_W-1:0]  vl_seq_i,
  input  logic [NUM_THR-1:0][PC_W-1:0]   vl_pc_i,
  input  logic [NUM_THR-1:0][SEQ_W-1:0]  vl_det_seq_i,
  output logic [NUM_THR-1:0]             sq_valid_o,
  output logic [NUM_THR-1:0][SEQ_W-1:0]  sq_seq_o,
  output logic [NUM_THR-1:0][PC_W-1:0]   sq_pc_o,
  output logic [NUM_THR-1:0]             sq_incl_o,
  output logic [NUM_THR-1:0]             sq_mispred_o,
  output logic [NUM_THR-1:0][CNT_W-1:0]  viol_cnt_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    sq_src_e          src;
    logic [SEQ_W-1:0] seq;
    logic [PC_W-1:0]  pc;

    sq_arb_pick #(.SEQ_W(SEQ_W), .PC_W(PC_W)) pick_i (
      .br_valid_i (br_valid_i[t]),
      .br_seq_i   (br_seq_i[t]),
      .br_tgt_i   (br_tgt_i[t]),
      .vl_valid_i (vl_valid_i[t]),
      .vl_seq_i   (vl_seq_i[t]),
      .vl_pc_i    (vl_pc_i[t]),
      .src_o      (src),
      .seq_o      (seq),
      .pc_o       (pc)
    );

    // command is rebuilt every cycle; idle cycles clear it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sq_valid_o[t]   <= 1'b0;
        sq_seq_o[t]     <= '0;
        sq_pc_o[t]      <= '0;
        sq_incl_o[t]    <= 1'b0;
        sq_mispred_o[t] <= 1'b0;
      end else begin
        sq_valid_o[t]   <= src != SRC_NONE;
        sq_seq_o[t]     <= seq;
        sq_pc_o[t]      <= pc;
        sq_incl_o[t]    <= src == SRC_VIOL;
        sq_mispred_o[t] <= src == SRC_BR;
      end
    end

    sq_arb_evt_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (vl_valid_i[t]),
      .cnt_o  (viol_cnt_o[t])
    );

    p_idle_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(br_valid_i[t] || vl_valid_i[t]) |=> !sq_valid_o[t]);

    p_br_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_i[t] && !vl_valid_i[t]) |=>
        (sq_valid_o[t] && sq_mispred_o[t] && !sq_incl_o[t]
         && sq_pc_o[t] == $past(br_tgt_i[t]) && sq_seq_o[t] == $past(br_seq_i[t])));

    p_viol_win_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vl_valid_i[t] && (!br_valid_i[t] || vl_seq_i[t] <= br_seq_i[t])) |=>
        (sq_valid_o[t] && sq_incl_o[t] && !sq_mispred_o[t]
         && sq_pc_o[t] == $past(vl_pc_i[t]) && sq_seq_o[t] == $past(vl_seq_i[t])));

    p_tie_viol_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_i[t] && vl_valid_i[t] && br_seq_i[t] == vl_seq_i[t]) |=>
        (sq_incl_o[t] && sq_pc_o[t] == $past(vl_pc_i[t])));

    p_br_older_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_valid_i[t] && vl_valid_i[t] && br_seq_i[t] < vl_seq_i[t]) |=>
        (sq_mispred_o[t] && !sq_incl_o[t] && sq_seq_o[t] == $past(br_seq_i[t])));

    p_det_distinct_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vl_valid_i[t] |-> vl_det_seq_i[t] != vl_seq_i[t]);

    p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> viol_cnt_o[t] == CNT_W'($past(viol_cnt_o[t]) + $past(vl_valid_i[t])));

    p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sq_incl_o[t] && sq_mispred_o[t]));
  end
endmodule

// File: tb/sq_arb_tb_top.sv
module sq_arb_tb_top;
  localparam int NT = 2;
  localparam int SW = 3;
  localparam int PW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]         br_v, vl_v;
  logic [NT-1:0][SW-1:0] br_s, vl_s, det_s;
  logic [NT-1:0][PW-1:0] br_t, vl_p;
  logic [NT-1:0]         sq_v, sq_i, sq_m;
  logic [NT-1:0][SW-1:0] sq_s;
  logic [NT-1:0][PW-1:0] sq_p;
  logic [NT-1:0][CW-1:0] cnt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sq_arb #(.NUM_THR(NT), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .br_valid_i(br_v), .br_seq_i(br_s), .br_tgt_i(br_t),
    .vl_valid_i(vl_v), .vl_seq_i(vl_s), .vl_pc_i(vl_p), .vl_det_seq_i(det_s),
    .sq_valid_o(sq_v), .sq_seq_o(sq_s), .sq_pc_o(sq_p),
    .sq_incl_o(sq_i), .sq_mispred_o(sq_m), .viol_cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ecnt[NT];
    br_v = '0; vl_v = '0; br_s = '0; vl_s = '0; det_s = '0; br_t = '0; vl_p = '0;
    #7;
    // R1: reset state
    for (int t = 0; t < NT; t++) begin
      chk(sq_v[t] == 0 && sq_i[t] == 0 && sq_m[t] == 0, "R1 flags", sq_v[t], 0);
      chk(sq_s[t] == 0 && sq_p[t] == 0, "R1 seq/pc", int'(sq_p[t]), 0);
      chk(cnt[t] == 0, "R1 counter", int'(cnt[t]), 0);
      ecnt[t] = 0;
    end
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 600; i++) begin
      int code [NT];
      code[0] = i % 256;
      code[1] = (i * 37 + 11) % 256;
      @(negedge clk);
      for (int t = 0; t < NT; t++) begin
        br_v[t]  = code[t][7];
        vl_v[t]  = code[t][6];
        br_s[t]  = SW'(code[t] >> 3);
        vl_s[t]  = SW'(code[t]);
        br_t[t]  = PW'(i * 5 + t);
        vl_p[t]  = PW'(i * 3 + 1 + t);
        det_s[t] = vl_s[t] ^ SW'(1 + (i % 7));  // R8: varies, never equal
      end
      @(posedge clk);
      #1;
      for (int t = 0; t < NT; t++) begin
        bit vw;
        string tag;
        ecnt[t] = (ecnt[t] + int'(vl_v[t])) % (1 << CW);
        vw = vl_v[t] && (!br_v[t] || vl_s[t] <= br_s[t]);
        if (!br_v[t] && !vl_v[t])        tag = "R2 idle";
        else if (!vl_v[t])               tag = "R3 branch only";
        else if (!br_v[t])               tag = "R4 violation only";
        else if (vl_s[t] < br_s[t])      tag = "R5 older violation";
        else if (vl_s[t] == br_s[t])     tag = "R6 tie";
        else                             tag = "R7 older branch";
        if (t == 1) tag = {tag, " R10"};
        chk(sq_v[t] == (br_v[t] || vl_v[t]), {tag, " valid"}, sq_v[t], br_v[t] || vl_v[t]);
        if (vw) begin
          chk(sq_s[t] == vl_s[t], {tag, " seq R8"}, sq_s[t], vl_s[t]);
          chk(sq_p[t] == vl_p[t], {tag, " pc"}, sq_p[t], vl_p[t]);
          chk(sq_i[t] == 1 && sq_m[t] == 0, {tag, " incl/mispred"}, {sq_i[t], sq_m[t]}, 2);
        end else if (br_v[t]) begin
          chk(sq_s[t] == br_s[t], {tag, " seq"}, sq_s[t], br_s[t]);
          chk(sq_p[t] == br_t[t], {tag, " pc"}, sq_p[t], br_t[t]);
          chk(sq_i[t] == 0 && sq_m[t] == 1, {tag, " incl/mispred"}, {sq_i[t], sq_m[t]}, 1);
        end
        chk(int'(cnt[t]) == ecnt[t], "R9 counter", int'(cnt[t]), ecnt[t]);
      end
    end
    @(negedge clk);
    br_v = '0; vl_v = '0;
    @(posedge clk);
    #1;
    for (int t = 0; t < NT; t++)
      chk(sq_v[t] == 0 && int'(cnt[t]) == ecnt[t], "R2 R9 final idle", sq_v[t], 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule